// File: doc/BRIEF.md
# Dual-Port Mailbox Interrupt Controller

This block runs beside a two-port memory of 2^ADDR_W words and lets the two sides signal each other. Each side owns one mailbox word at the top of the address space. The left side's mailbox is the second-highest word (all ones except bit 0, 0x7FE for 11 address bits). The right side's mailbox is the highest word (all ones, 0x7FF). When one side writes into the other side's mailbox, an active-low interrupt is raised toward the receiving side. The receiver drops its interrupt by accessing its own mailbox with its select and read enable both active.

The mailbox words stay ordinary memory locations, and the memory array stores the message. This block only watches the access controls of each side and keeps the two pending flags. Each side gives a select, a read enable, a write enable, an address and an inhibit input. The inhibit input is the busy or write-block status that arbitration logic outside this block produces for that side. An inhibited access has no effect on either flag. A global enable lets a system that does not use mailboxes hold both interrupts inactive. The two mailbox words then behave as plain memory.

All inputs are sampled on the rising clock edge. A flag change shows on its interrupt output one clock after the access that caused it.

Top module: `mbx_irq_ctrl`

## Requirements
- R1: When the right side has sel=1, wr_en=1 and inhibit=0 with address 0x7FE, and mbx_en=1, l_irq_n is 0 from the next clock onward.
- R2: When the left side has sel=1, wr_en=1 and inhibit=0 with address 0x7FF, and mbx_en=1, r_irq_n is 0 from the next clock onward.
- R3: When the left side has sel=1, rd_en=1 and inhibit=0 with address 0x7FE, l_irq_n returns to 1 at the next clock. The value of its wr_en does not matter.
- R4: When the right side has sel=1, rd_en=1 and inhibit=0 with address 0x7FF, r_irq_n returns to 1 at the next clock. The value of its wr_en does not matter.
- R5: A side whose inhibit input is 1 neither raises the other side's flag nor clears its own flag.
- R6: If a set and a clear for the same flag fall in the same cycle, the flag is left asserted (0).
- R7: While mbx_en=0, both interrupt outputs are 1 from the next clock onward and every access is ignored.
- R8: During reset (rst_n=0) and at the first cycle after it, both interrupt outputs are 1.
- R9: The following accesses leave both flags unchanged:
  - any access to an address other than the two mailboxes;
  - an access with sel=0;
  - a write by a side into its own mailbox without rd_en;
  - a read by a side of the other side's mailbox.
- R10: Activity on one flag never changes the other flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| mbx_en | input | 1 | Global mailbox enable, active high |
| l_sel | input | 1 | Left side select, active high |
| l_rd_en | input | 1 | Left side read (output) enable, active high |
| l_wr_en | input | 1 | Left side write strobe, active high |
| l_inhibit | input | 1 | Left side busy or write-inhibit status, active high |
| l_addr | input | ADDR_W | Left side word address |
| r_sel | input | 1 | Right side select, active high |
| r_rd_en | input | 1 | Right side read (output) enable, active high |
| r_wr_en | input | 1 | Right side write strobe, active high |
| r_inhibit | input | 1 | Right side busy or write-inhibit status, active high |
| r_addr | input | ADDR_W | Right side word address |
| l_irq_n | output | 1 | Interrupt toward the left side, active low |
| r_irq_n | output | 1 | Interrupt toward the right side, active low |

## Verification
The bench uses near-exhaustive sweeps. For each side, it tries all sixteen combinations of select, read enable, write enable and inhibit, each against five addresses: both mailboxes, word zero, the word just below the mailboxes, and a mid-range word. Each combination starts from both a raised and a cleared flag. Together these separate:
- a set from a clear;
- a correct mailbox from the wrong one;
- an inhibited access from an accepted one;
- a change on one flag from a disturbance of the other.

Separate patterns drive both sides together so that a set and a clear land in the same cycle. They also toggle the global enable while accesses are pending.

// File: rtl/mbx_pkg.sv
package mbx_pkg;

    // Access controls of one side, all active high
    typedef struct packed {
        logic sel;
        logic rd_en;
        logic wr_en;
        logic inhibit;
    } port_ctl_t;

    // Decoded mailbox events of one side
    typedef struct packed {
        logic post;   // accepted write into the peer's mailbox
        logic ack;    // accepted access to the own mailbox
    } mbx_evt_t;

    // Register state of one pending flag
    typedef struct packed {
        logic pend;
    } flag_state_t;

    localparam int unsigned NUM_SIDES = 2;
    localparam int unsigned SIDE_L    = 0;
    localparam int unsigned SIDE_R    = 1;

endpackage

// File: rtl/mbx_port_decode.sv
module mbx_port_decode
    import mbx_pkg::*;
#(
    parameter int unsigned ADDR_W   = 11,
    parameter logic [ADDR_W-1:0] OWN_BOX  = '1,
    parameter logic [ADDR_W-1:0] PEER_BOX = '0
) (
    input  port_ctl_t         ctl,
    input  logic [ADDR_W-1:0] addr,
    output mbx_evt_t          evt
);

    logic hit_own;
    logic hit_peer;
    logic granted;

    always_comb begin
        hit_own  = (addr == OWN_BOX);
        hit_peer = (addr == PEER_BOX);
        granted  = ctl.sel && !ctl.inhibit;
        evt.post = granted && ctl.wr_en && hit_peer;
        evt.ack  = granted && ctl.rd_en && hit_own;
    end

endmodule

// File: rtl/mbx_flag_cell.sv
module mbx_flag_cell
    import mbx_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic set_evt,
    input  logic clr_evt,
    output logic pend
);

    flag_state_t state_d;
    flag_state_t state_q;

    always_comb begin
        state_d = state_q;
        if (!enable) begin
            state_d.pend = 1'b0;
        end else if (set_evt) begin
            // a fresh message wins over a simultaneous acknowledge
            state_d.pend = 1'b1;
        end else if (clr_evt) begin
            state_d.pend = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign pend = state_q.pend;

endmodule

// File: rtl/mbx_irq_ctrl.sv
module mbx_irq_ctrl
    import mbx_pkg::*;
#(
    parameter int unsigned ADDR_W = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mbx_en,
    input  logic              l_sel,
    input  logic              l_rd_en,
    input  logic              l_wr_en,
    input  logic              l_inhibit,
    input  logic [ADDR_W-1:0] l_addr,
    input  logic              r_sel,
    input  logic              r_rd_en,
    input  logic              r_wr_en,
    input  logic              r_inhibit,
    input  logic [ADDR_W-1:0] r_addr,
    output logic              l_irq_n,
    output logic              r_irq_n
);

    localparam logic [ADDR_W-1:0] TOP_WORD = '1;
    localparam logic [ADDR_W-1:0] L_BOX    = TOP_WORD - 1'b1;
    localparam logic [ADDR_W-1:0] R_BOX    = TOP_WORD;

    port_ctl_t         ctl  [NUM_SIDES];
    logic [ADDR_W-1:0] addr [NUM_SIDES];
    mbx_evt_t          evt  [NUM_SIDES];
    logic              pend [NUM_SIDES];

    always_comb begin
        ctl[SIDE_L]  = '{sel: l_sel, rd_en: l_rd_en, wr_en: l_wr_en, inhibit: l_inhibit};
        ctl[SIDE_R]  = '{sel: r_sel, rd_en: r_rd_en, wr_en: r_wr_en, inhibit: r_inhibit};
        addr[SIDE_L] = l_addr;
        addr[SIDE_R] = r_addr;
    end

    for (genvar i = 0; i < NUM_SIDES; i++) begin : g_side
        localparam logic [ADDR_W-1:0] OWN  = (i == SIDE_L) ? L_BOX : R_BOX;
        localparam logic [ADDR_W-1:0] PEER = (i == SIDE_L) ? R_BOX : L_BOX;
        localparam int unsigned       OTHER = NUM_SIDES - 1 - i;

        mbx_port_decode #(
            .ADDR_W  (ADDR_W),
            .OWN_BOX (OWN),
            .PEER_BOX(PEER)
        ) u_dec (
            .ctl (ctl[i]),
            .addr(addr[i]),
            .evt (evt[i])
        );

        // flag toward side i: raised by the other side, dropped by side i
        mbx_flag_cell u_flag (
            .clk    (clk),
            .rst_n  (rst_n),
            .enable (mbx_en),
            .set_evt(evt[OTHER].post),
            .clr_evt(evt[i].ack),
            .pend   (pend[i])
        );
    end

    assign l_irq_n = ~pend[SIDE_L];
    assign r_irq_n = ~pend[SIDE_R];

endmodule

// File: rtl/mbx_irq_checker.sv
module mbx_irq_checker #(
    parameter int unsigned ADDR_W = 11
) (
    input logic              clk,
    input logic              rst_n,
    input logic              mbx_en,
    input logic              l_sel,
    input logic              l_rd_en,
    input logic              l_wr_en,
    input logic              l_inhibit,
    input logic [ADDR_W-1:0] l_addr,
    input logic              r_sel,
    input logic              r_rd_en,
    input logic              r_wr_en,
    input logic              r_inhibit,
    input logic [ADDR_W-1:0] r_addr,
    input logic              l_irq_n,
    input logic              r_irq_n
);

    localparam logic [ADDR_W-1:0] HI = '1;
    localparam logic [ADDR_W-1:0] LB = HI - 1'b1;

    logic set_l, set_r, clr_l, clr_r;
    assign set_l = mbx_en && r_sel && r_wr_en && !r_inhibit && (r_addr == LB);
    assign set_r = mbx_en && l_sel && l_wr_en && !l_inhibit && (l_addr == HI);
    assign clr_l = l_sel && l_rd_en && !l_inhibit && (l_addr == LB);
    assign clr_r = r_sel && r_rd_en && !r_inhibit && (r_addr == HI);

    // R1 and R6: an accepted post raises the left flag
    p_post_left_r1: assert property (@(posedge clk) disable iff (!rst_n)
        set_l |=> !l_irq_n);
    // R2 and R6
    p_post_right_r2: assert property (@(posedge clk) disable iff (!rst_n)
        set_r |=> !r_irq_n);
    // R3
    p_ack_left_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_l && !set_l) |=> l_irq_n);
    // R4
    p_ack_right_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_r && !set_r) |=> r_irq_n);
    // R5, R9: a flag only falls after an accepted post
    p_no_spurious_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (l_irq_n && !set_l) |=> l_irq_n);
    p_no_spurious_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (r_irq_n && !set_r) |=> r_irq_n);
    // R10: a raised flag stays raised unless acknowledged
    p_hold_left_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!l_irq_n && mbx_en && !clr_l) |=> !l_irq_n);
    // R7
    p_gate_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !mbx_en |=> (l_irq_n && r_irq_n));

    // R8
    always @(posedge clk) begin
        if (!rst_n) begin
            p_reset_idle_r8: assert (l_irq_n && r_irq_n);
        end
    end

endmodule

bind mbx_irq_ctrl mbx_irq_checker #(.ADDR_W(ADDR_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .mbx_en   (mbx_en),
    .l_sel    (l_sel),
    .l_rd_en  (l_rd_en),
    .l_wr_en  (l_wr_en),
    .l_inhibit(l_inhibit),
    .l_addr   (l_addr),
    .r_sel    (r_sel),
    .r_rd_en  (r_rd_en),
    .r_wr_en  (r_wr_en),
    .r_inhibit(r_inhibit),
    .r_addr   (r_addr),
    .l_irq_n  (l_irq_n),
    .r_irq_n  (r_irq_n)
);

// File: tb/sim_mbx_irq_ctrl.sv
`timescale 1ns/1ps
module sim_mbx_irq_ctrl;

    localparam int unsigned AW = 11;
    localparam logic [AW-1:0] LBOX = 11'h7FE;
    localparam logic [AW-1:0] RBOX = 11'h7FF;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic mbx_en = 1'b1;
    logic l_sel = 0, l_rd_en = 0, l_wr_en = 0, l_inhibit = 0;
    logic r_sel = 0, r_rd_en = 0, r_wr_en = 0, r_inhibit = 0;
    logic [AW-1:0] l_addr = '0, r_addr = '0;
    logic l_irq_n, r_irq_n;

    int n_chk = 0;
    int n_fail = 0;
    bit exp_l = 0, exp_r = 0;   // expected pending state (1 = interrupt active)
    bit done = 0;

    always #2.5 clk = ~clk;

    mbx_irq_ctrl #(.ADDR_W(AW)) u0 (
        .clk(clk), .rst_n(rst_n), .mbx_en(mbx_en),
        .l_sel(l_sel), .l_rd_en(l_rd_en), .l_wr_en(l_wr_en), .l_inhibit(l_inhibit), .l_addr(l_addr),
        .r_sel(r_sel), .r_rd_en(r_rd_en), .r_wr_en(r_wr_en), .r_inhibit(r_inhibit), .r_addr(r_addr),
        .l_irq_n(l_irq_n), .r_irq_n(r_irq_n)
    );

    function automatic logic [AW-1:0] pick_addr(int k);
        case (k)
            0: return LBOX;
            1: return RBOX;
            2: return '0;
            3: return 11'h7FD;
            default: return 11'h3FF;
        endcase
    endfunction

    task automatic check(string tag, logic act, logic exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %b expected %b at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic idle();
        {l_sel, l_rd_en, l_wr_en, l_inhibit} = 4'b0;
        {r_sel, r_rd_en, r_wr_en, r_inhibit} = 4'b0;
    endtask

    // drive current inputs for one edge, update the model, check both outputs
    task automatic step();
        bit sl, sr, cl, cr;
        string tl, tr;
        sl = r_sel && r_wr_en && !r_inhibit && r_addr == LBOX;
        sr = l_sel && l_wr_en && !l_inhibit && l_addr == RBOX;
        cl = l_sel && l_rd_en && !l_inhibit && l_addr == LBOX;
        cr = r_sel && r_rd_en && !r_inhibit && r_addr == RBOX;
        if (!mbx_en)       begin tl = "R7"; tr = "R7"; end
        else begin
            tl = (sl && cl) ? "R6" : sl ? "R1" : cl ? "R3" : (l_inhibit || r_inhibit) ? "R5" : (sr || cr) ? "R10" : "R9";
            tr = (sr && cr) ? "R6" : sr ? "R2" : cr ? "R4" : (l_inhibit || r_inhibit) ? "R5" : (sl || cl) ? "R10" : "R9";
        end
        if (!mbx_en) begin exp_l = 0; exp_r = 0; end
        else begin
            exp_l = sl ? 1'b1 : cl ? 1'b0 : exp_l;
            exp_r = sr ? 1'b1 : cr ? 1'b0 : exp_r;
        end
        @(posedge clk); #1;
        check({tl, " left"},  l_irq_n, ~exp_l);
        check({tr, " right"}, r_irq_n, ~exp_r);
    endtask

    task automatic force_flag(int side, bit val);
        idle();
        if (side == 0) begin
            if (val) begin r_sel = 1; r_wr_en = 1; r_addr = LBOX; end
            else     begin l_sel = 1; l_rd_en = 1; l_addr = LBOX; end
        end else begin
            if (val) begin l_sel = 1; l_wr_en = 1; l_addr = RBOX; end
            else     begin r_sel = 1; r_rd_en = 1; r_addr = RBOX; end
        end
        step();
        idle();
    endtask

    initial begin
        repeat (1000000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        // R8: reset state
        repeat (3) @(posedge clk);
        #1;
        check("R8 reset left", l_irq_n, 1'b1);
        check("R8 reset right", r_irq_n, 1'b1);
        rst_n = 1'b1;
        @(posedge clk); #1;
        check("R8 after reset left", l_irq_n, 1'b1);
        check("R8 after reset right", r_irq_n, 1'b1);

        // sweep: every control pattern and address, on each side, from both flag states
        for (int side = 0; side < 2; side++) begin
            for (int pre = 0; pre < 2; pre++) begin
                for (int c = 0; c < 16; c++) begin
                    for (int a = 0; a < 5; a++) begin
                        force_flag(0, pre[0]);
                        force_flag(1, pre[0]);
                        idle();
                        if (side == 0) begin
                            {l_sel, l_rd_en, l_wr_en, l_inhibit} = c[3:0];
                            l_addr = pick_addr(a);
                        end else begin
                            {r_sel, r_rd_en, r_wr_en, r_inhibit} = c[3:0];
                            r_addr = pick_addr(a);
                        end
                        step();
                        idle();
                        step();
                    end
                end
            end
        end

        // R6: simultaneous set and clear on each flag
        force_flag(0, 1);
        r_sel = 1; r_wr_en = 1; r_addr = LBOX;
        l_sel = 1; l_rd_en = 1; l_addr = LBOX;
        step(); idle(); step();
        force_flag(1, 1);
        l_sel = 1; l_wr_en = 1; l_addr = RBOX;
        r_sel = 1; r_rd_en = 1; r_addr = RBOX;
        step(); idle(); step();

        // R5: inhibited clear keeps both flags raised
        force_flag(0, 1); force_flag(1, 1);
        l_sel = 1; l_rd_en = 1; l_inhibit = 1; l_addr = LBOX;
        r_sel = 1; r_rd_en = 1; r_inhibit = 1; r_addr = RBOX;
        step(); idle(); step();

        // R7: enable low clears and blocks posts
        mbx_en = 0;
        step();
        r_sel = 1; r_wr_en = 1; r_addr = LBOX;
        l_sel = 1; l_wr_en = 1; l_addr = RBOX;
        step(); step();
        idle();
        mbx_en = 1;
        step();
        force_flag(0, 1);
        force_flag(1, 1);
        step();

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule